// File: doc/BRIEF.md
# Two-Level Dual-CPU Interrupt Gate

This block collects level interrupt lines from devices and delivers each one to one or both of two CPUs. A source reaches a CPU only when it passes two gates: a shared enable that covers the whole system, and a mask that belongs to the receiving CPU alone. Each source also has a routing field that picks the CPUs it may target. Software never edits these bits by read-modify-write. It writes a source number to a dedicated set or clear location, and the block changes only that source.

The register bus has two windows, chosen by `bus_win`. The global window (0) holds a size descriptor, the enable set and clear locations, and one routing word per source. The per-CPU window (1) is banked by `bus_cpu`. It holds the mask set and clear locations and an acknowledge word that names the lowest-numbered source currently deliverable to the CPU making the access. Sources up to number 28 are per-CPU lines and may be routed to both CPUs. Higher-numbered sources are shared lines and always end up routed to at most one CPU.

A three-state access controller classifies every bus cycle. ST_IDLE means no access, ST_WR means a write commits this edge, and ST_RD means read data was captured this edge. From any state it moves to ST_WR on `bus_valid && bus_write`, to ST_RD on `bus_valid && !bus_write`, and to ST_IDLE otherwise.

Top module: `dual_gate_intc`

## Requirements
- R1: After reset, `cpu_irq` is 0 for both CPUs, every routing word reads 0, and the acknowledge word of each CPU reads 1023.
- R2: A write of source number n to global offset 0x030 sets the shared enable of source n. A write of n to global offset 0x034 clears it. No other source's enable changes.
- R3: A write of n to per-CPU offset 0x048 masks source n for the CPU given by `bus_cpu` only. A write of n to offset 0x04C unmasks it for that CPU only.
- R4: The routing word of source i is at global offset 0x100 + 4*i. Bit c (c = 0 or 1) routes the source to CPU c. A read returns the stored bits in [1:0] and zeros above them.
- R5: For a shared source (number greater than 28), a routing write keeps only the lowest set bit of wdata[1:0]. Per-CPU sources (number 28 or lower) store both bits as written.
- R6: Source n is deliverable to CPU c exactly when irq_in[n] is high, its shared enable is set, routing bit c is set and it is not masked for CPU c. Delivery follows the level input in the same cycle.
- R7: When several sources are deliverable to a CPU, the acknowledge word names the lowest-numbered one.
- R8: The acknowledge word at per-CPU offset 0x044 holds the winning source number in bits [9:0], or 1023 if none is deliverable. `cpu_irq[c]` is high exactly when CPU c's acknowledge word would not be 1023.
- R9: Global offset 0x000 reads the number of implemented sources in bits [11:2]. All other bits read 0.
- R10: Enable and mask writes that carry a source number at or above the number of implemented sources change nothing.
- R11: Read data appears on `bus_rdata` at the clock edge that ends the read cycle. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_win | input | 1 | 0 = global window, 1 = per-CPU window |
| bus_cpu | input | 1 | Identity of the accessing CPU |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_in | input | 32 | Level interrupt sources |
| cpu_irq | output | 2 | Interrupt request, one per CPU |

## Verification
Most faults in this block's state show up combinationally on `cpu_irq` within one cycle of the write that caused them. A wrong enable, mask or routing bit raises or drops a CPU's request as soon as a matching source is asserted. Such a fault also changes the acknowledge number on the next read. Banking faults, where a write lands on the wrong CPU's mask, show up as the other CPU's request changing. Decode faults for out-of-range or shared-source writes stay hidden until a source is made otherwise deliverable, so the directed cases build that setup first and then look at the request lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ACK_W = 10;
    localparam logic [ACK_W-1:0] ACK_NONE = 10'd1023;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR,
        ST_RD
    } acc_state_e;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic msk_set;
        logic msk_clr;
        logic route_wr;
    } gate_cmd_t;
endpackage

// File: rtl/irqc_gate_bank.sv
module irqc_gate_bank
    import irqc_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int NUM_CPU    = 2,
    parameter int PERCPU_MAX = 28,
    parameter int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  gate_cmd_t                           cmd,
    input  logic [ACK_W-1:0]                    idx,
    input  logic [CPU_W-1:0]                    cpu_sel,
    input  logic [NUM_CPU-1:0]                  route_val,
    output logic [NUM_SRC-1:0]                  en,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]     mask,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]     route
);
    logic                 idx_ok;
    logic [NUM_CPU-1:0]   route_low;

    assign idx_ok    = int'(idx) < NUM_SRC;
    // lowest set bit of the written routing field
    assign route_low = route_val & (~route_val + NUM_CPU'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en    <= '0;
            mask  <= '1;
            route <= '0;
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (idx_ok && idx == ACK_W'(i)) begin
                    if (cmd.en_set)
                        en[i] <= 1'b1;
                    else if (cmd.en_clr)
                        en[i] <= 1'b0;
                    if (cmd.route_wr)
                        route[i] <= (i > PERCPU_MAX) ? route_low : route_val;
                    for (int c = 0; c < NUM_CPU; c++) begin
                        if (cpu_sel == CPU_W'(c)) begin
                            if (cmd.msk_set)
                                mask[c][i] <= 1'b1;
                            else if (cmd.msk_clr)
                                mask[c][i] <= 1'b0;
                        end
                    end
                end
            end
        end
    end

    // out-of-range numbers leave every enable untouched
    p_range_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_ok |=> $stable(en));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
        p_enable_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.en_set && idx == ACK_W'(i)) |=> en[i]);
        p_enable_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd.en_clr && idx == ACK_W'(i)) |=> !en[i]);
        if (i > PERCPU_MAX) begin : g_shared
            p_single_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(route[i]));
        end
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] req,
    output logic [ACK_W-1:0]   ack,
    output logic               hit
);
    always_comb begin
        ack = ACK_NONE;
        hit = 1'b0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                ack = ACK_W'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 2,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_valid,
    input  logic                            bus_write,
    input  logic                            bus_win,
    input  logic [CPU_W-1:0]                bus_cpu,
    input  logic [11:0]                     bus_addr,
    input  logic [31:0]                     bus_wdata,
    input  logic [NUM_SRC-1:0][NUM_CPU-1:0] route,
    input  logic [NUM_CPU-1:0][ACK_W-1:0]   ack_all,
    output gate_cmd_t                       cmd,
    output logic [ACK_W-1:0]                idx,
    output logic [CPU_W-1:0]                cpu_sel,
    output logic [NUM_CPU-1:0]              route_val,
    output logic [31:0]                     bus_rdata
);
    localparam logic [11:0] OFS_DESC   = 12'h000;
    localparam logic [11:0] OFS_EN_SET = 12'h030;
    localparam logic [11:0] OFS_EN_CLR = 12'h034;
    localparam logic [11:0] OFS_ACK    = 12'h044;
    localparam logic [11:0] OFS_MK_SET = 12'h048;
    localparam logic [11:0] OFS_MK_CLR = 12'h04C;

    acc_state_e state, next_state;
    logic       in_route;
    logic [31:0] rd_val;
    logic [21:0] unused_wdata;

    assign unused_wdata = bus_wdata[31:10];
    assign in_route = (bus_addr[11:8] == 4'h1) && (bus_addr[1:0] == 2'b00)
                   && (int'(bus_addr[7:2]) < NUM_SRC);

    always_comb begin
        unique case ({bus_valid, bus_write})
            2'b11:   next_state = ST_WR;
            2'b10:   next_state = ST_RD;
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= next_state;
    end

    // write decode and read mux
    always_comb begin
        cmd       = '0;
        idx       = bus_wdata[ACK_W-1:0];
        cpu_sel   = bus_cpu;
        route_val = bus_wdata[NUM_CPU-1:0];
        rd_val    = '0;
        unique case (next_state)
            ST_WR: begin
                if (!bus_win) begin
                    cmd.en_set = (bus_addr == OFS_EN_SET);
                    cmd.en_clr = (bus_addr == OFS_EN_CLR);
                    if (in_route) begin
                        cmd.route_wr = 1'b1;
                        idx = {4'b0, bus_addr[7:2]};
                    end
                end else begin
                    cmd.msk_set = (bus_addr == OFS_MK_SET);
                    cmd.msk_clr = (bus_addr == OFS_MK_CLR);
                end
            end
            ST_RD: begin
                if (!bus_win) begin
                    if (bus_addr == OFS_DESC)
                        rd_val = {20'b0, ACK_W'(NUM_SRC), 2'b00};
                    else if (in_route)
                        for (int i = 0; i < NUM_SRC; i++)
                            if (bus_addr[7:2] == 6'(i))
                                rd_val = 32'(route[i]);
                end else if (bus_addr == OFS_ACK) begin
                    rd_val = 32'(ack_all[bus_cpu]);
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (next_state == ST_RD)
            bus_rdata <= rd_val;
    end

    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));
    p_read_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |-> ($past(bus_valid) && !$past(bus_write)));
endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
    import irqc_pkg::*;
#(
    parameter int NUM_SRC    = 32,
    parameter int NUM_CPU    = 2,
    parameter int PERCPU_MAX = 28,
    parameter int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic               bus_win,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic [NUM_CPU-1:0] cpu_irq
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    gate_cmd_t                        cmd;
    logic [ACK_W-1:0]                 idx;
    logic [CPU_W-1:0]                 cpu_sel;
    logic [NUM_CPU-1:0]               route_val;
    logic [NUM_SRC-1:0]               en;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  mask;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]  route;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]  req_vec;
    logic [NUM_CPU-1:0][ACK_W-1:0]    ack_all;

    irqc_regif #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_regif (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_win(bus_win), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .route(route), .ack_all(ack_all), .cmd(cmd),
        .idx(idx), .cpu_sel(cpu_sel), .route_val(route_val), .bus_rdata(bus_rdata)
    );

    irqc_gate_bank #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU),
                     .PERCPU_MAX(PERCPU_MAX), .CPU_W(CPU_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .idx(idx), .cpu_sel(cpu_sel),
        .route_val(route_val), .en(en), .mask(mask), .route(route)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic [SRC_W-1:0] win;

        always_comb
            for (int i = 0; i < NUM_SRC; i++)
                req_vec[c][i] = irq_in[i] & en[i] & route[i][c] & ~mask[c][i];

        irqc_pick #(.NUM_SRC(NUM_SRC)) u_pick (
            .req(req_vec[c]), .ack(ack_all[c]), .hit(cpu_irq[c])
        );

        assign win = ack_all[c][SRC_W-1:0];

        p_winner_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> (irq_in[win] && en[win] && route[win][c] && !mask[c][win]));
        p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> ((req_vec[c] & ((NUM_SRC'(1) << win) - NUM_SRC'(1))) == '0));
    end
endmodule

// File: tb/dual_gate_intc_bench.sv
module dual_gate_intc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_win = 1'b0;
    logic [0:0]  bus_cpu = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_in = '0;
    logic [1:0]  cpu_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dual_gate_intc u_dual_gate_intc (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_win(bus_win), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input bit win, input bit cpu, input logic [11:0] a, input int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_win = win; bus_cpu = cpu;
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input bit win, input bit cpu, input logic [11:0] a, output int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_win = win; bus_cpu = cpu; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic chk_irq(input int exp, input string tag);
        @(negedge clk);
        check(cpu_irq == exp[1:0], tag, cpu_irq, exp);
    endtask

    function automatic logic [11:0] rt(input int s);
        return 12'(32'h100 + 4 * s);
    endfunction

    task automatic t_reset();
        int v;
        chk_irq(0, "R1 irq after reset");
        rd(1, 0, 12'h044, v); check(v == 1023, "R1 ack cpu0", v, 1023);
        rd(1, 1, 12'h044, v); check(v == 1023, "R1 ack cpu1", v, 1023);
        rd(0, 0, rt(5), v);   check(v == 0, "R1 route reset", v, 0);
        rd(0, 0, 12'h000, v); check(v == (32 << 2), "R9 size descriptor", v, 128);
    endtask

    task automatic t_enable();
        int v;
        irq_in = 32'h0000_0020;
        wr(0, 0, rt(5), 1);
        wr(1, 0, 12'h04C, 5);
        chk_irq(0, "R6 not enabled");
        wr(0, 0, 12'h030, 5);
        chk_irq(1, "R2 enable set");
        rd(1, 0, 12'h044, v); check(v == 5, "R8 ack cpu0", v, 5);
        rd(1, 1, 12'h044, v); check(v == 1023, "R8 ack cpu1 idle", v, 1023);
        wr(0, 0, 12'h034, 5);
        chk_irq(0, "R2 enable clear");
    endtask

    task automatic t_banked_mask();
        int v;
        wr(0, 0, 12'h030, 5);
        wr(0, 0, rt(5), 3);
        chk_irq(1, "R3 cpu1 still masked");
        wr(1, 1, 12'h04C, 5);
        chk_irq(3, "R3 cpu1 unmask");
        wr(1, 0, 12'h048, 5);
        chk_irq(2, "R3 cpu0 mask only");
        rd(0, 0, rt(5), v); check(v == 3, "R4 route readback", v, 3);
        wr(0, 0, 12'h034, 5);
        irq_in = '0;
        chk_irq(0, "R6 cleanup");
    endtask

    task automatic t_priority();
        int v;
        irq_in = 32'h0000_0208;
        wr(0, 0, rt(3), 1); wr(0, 0, rt(9), 1);
        wr(1, 0, 12'h04C, 3); wr(1, 0, 12'h04C, 9);
        wr(0, 0, 12'h030, 9); wr(0, 0, 12'h030, 3);
        rd(1, 0, 12'h044, v); check(v == 3, "R7 lowest wins", v, 3);
        irq_in[3] = 1'b0;
        rd(1, 0, 12'h044, v); check(v == 9, "R7 next after drop", v, 9);
        wr(1, 0, 12'h048, 9);
        chk_irq(0, "R8 irq low when none");
        rd(1, 0, 12'h044, v); check(v == 1023, "R8 idle code", v, 1023);
        wr(0, 0, 12'h034, 3); wr(0, 0, 12'h034, 9);
        irq_in = '0;
    endtask

    task automatic t_shared_route();
        int v;
        wr(0, 0, rt(30), 3); rd(0, 0, rt(30), v); check(v == 1, "R5 shared keeps lowest", v, 1);
        wr(0, 0, rt(31), 2); rd(0, 0, rt(31), v); check(v == 2, "R5 shared single", v, 2);
        wr(0, 0, rt(28), 32'h103); rd(0, 0, rt(28), v); check(v == 3, "R4 R5 per-cpu both, upper zero", v, 3);
    endtask

    task automatic t_range_ignore();
        int v;
        irq_in = 32'h0000_0100;
        wr(0, 0, rt(8), 1);
        wr(1, 0, 12'h04C, 8);
        wr(0, 0, 12'h030, 40);
        chk_irq(0, "R10 out-of-range enable ignored");
        wr(0, 0, 12'h030, 8);
        chk_irq(1, "R2 in-range enable");
        wr(1, 0, 12'h048, 40);
        chk_irq(1, "R10 out-of-range mask ignored");
    endtask

    task automatic t_read_hold();
        int v;
        rd(1, 0, 12'h044, v); check(v == 8, "R11 read value", v, 8);
        irq_in = '0;
        repeat (3) @(negedge clk);
        check(bus_rdata == 8, "R11 data held", bus_rdata, 8);
        rd(1, 0, 12'h044, v); check(v == 1023, "R11 fresh read", v, 1023);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_banked_mask();
        t_priority();
        t_shared_route();
        t_range_ignore();
        t_read_hold();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule